// File: doc/BRIEF.md
# Temperature Slew Rate Monitor

This block turns a stream of temperature conversion results into a rate of change and watches that rate against a programmable upper bound. Each time a new signed 14-bit result arrives with its valid strobe while the converter runs continuously, the block subtracts the result it kept from the previous conversion. It scales the difference by the conversion rate to give degrees per second, clamps the value to the 14-bit signed range and presents it. The result uses 0.03125 °C/s per LSB. It appears left-justified in a 16-bit word whose two lowest bits are zero.

The rate is valid only once two back-to-back continuous samples have been seen. When continuous operation stops, the stored sample is dropped and the output returns to zero. Only rising temperature is judged against the limit. The limit is a 13-bit unsigned value with the same LSB, covering 0 to 256 °C/s; a status bit follows the comparison, and a one-clock event pulse marks each new crossing for a flag register further downstream. A negative result only shows direction in its sign bit; its size is not guaranteed to be accurate.

Top module: `slew_rate_monitor`

## Requirements
- R1: After reset, slew_word is zero and slew_high and slew_event are low.
- R2: After reset or after re-entering continuous mode, the first valid sample produces no result: slew_word keeps its value of zero. From the second consecutive valid sample on, a result is presented in the cycle after the capturing clock edge.
- R3: The result is (current − previous sample) scaled by rate_code: 3'd1 ×32, 3'd2 ×16, 3'd3 ×8, 3'd4 ×4, 3'd5 ×2, 3'd6 ×1, 3'd7 halved with rounding toward minus infinity, and 3'd0 ×166.
- R4: A scaled value above 8191 is presented as 8191, and one below −8192 as −8192.
- R5: While cont_mode is low, the next clock edge clears slew_word and slew_high, forgets the stored sample and ignores sample_valid.
- R6: slew_word[15:2] carries the 14-bit two's complement result, and slew_word[1:0] is always zero.
- R7: On each new result, slew_high is set only if the result is non-negative and strictly greater than slew_limit (unsigned). A result equal to the limit, or any negative result, clears it.
- R8: slew_event is high for exactly one clock when a new result sets slew_high and slew_high was low before that result; a further exceeding result while slew_high is already high gives no pulse.
- R9: While no valid sample arrives in continuous mode, slew_word and slew_high hold their values, even if rate_code or slew_limit change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | Strobe: sample_temp holds a new conversion result |
| sample_temp | input | 14 | Conversion result, two's complement, 0.03125 °C per LSB |
| cont_mode | input | 1 | High while conversions run continuously |
| rate_code | input | 3 | Conversion rate selector used for scaling |
| slew_limit | input | 13 | Unsigned rising-rate limit, 0.03125 °C/s per LSB |
| slew_word | output | 16 | Slew result in bits 15:2, bits 1:0 zero |
| slew_high | output | 1 | Live status: last result exceeded the limit |
| slew_event | output | 1 | One-clock pulse on a new crossing of the limit |

## Verification
The hardest case to reach is a second exceeding result that arrives while the status is already set, where the event pulse must stay low. The stimulus also has to produce the one-sample gap after continuous mode is re-entered, and a valid strobe sent while continuous mode is off. The bench reaches these states with directed sample sequences. One sequence steps just below, exactly at and just above a small limit. Another holds cont_mode low for one cycle, pulses sample_valid during that cycle, and then checks that the next sample gives no result. Saturation is reached with a large temperature step at the ×32 rate.

// File: rtl/slew_mon_pkg.sv
package slew_mon_pkg;

    // Conversion rate selector; the scale applied to a sample difference
    typedef enum logic [2:0] {
        RATE_X166 = 3'd0,
        RATE_X32  = 3'd1,
        RATE_X16  = 3'd2,
        RATE_X8   = 3'd3,
        RATE_X4   = 3'd4,
        RATE_X2   = 3'd5,
        RATE_X1   = 3'd6,
        RATE_HALF = 3'd7
    } rate_e;

    // Extra headroom bits needed by the largest scale factor (166 < 2^8)
    localparam int unsigned SCALE_HEADROOM = 8;

endpackage

// File: rtl/slew_diff_scale.sv
module slew_diff_scale
    import slew_mon_pkg::*;
#(
    parameter int unsigned IN_W   = 14,
    parameter int unsigned WIDE_W = IN_W + 1 + SCALE_HEADROOM
) (
    input  logic signed [IN_W-1:0]   cur_sample,
    input  logic signed [IN_W-1:0]   prev_sample,
    input  logic [2:0]               rate_code,
    output logic signed [WIDE_W-1:0] scaled
);

    localparam int unsigned DIFF_W = IN_W + 1;

    logic signed [DIFF_W-1:0] diff;
    logic signed [WIDE_W-1:0] ext;

    always_comb begin
        diff = $signed({cur_sample[IN_W-1], cur_sample})
             - $signed({prev_sample[IN_W-1], prev_sample});
        ext  = $signed({{(WIDE_W-DIFF_W){diff[DIFF_W-1]}}, diff});
    end

    always_comb begin
        unique case (rate_e'(rate_code))
            RATE_X166: scaled = (ext <<< 7) + (ext <<< 5) + (ext <<< 2) + (ext <<< 1);
            RATE_X32:  scaled = ext <<< 5;
            RATE_X16:  scaled = ext <<< 4;
            RATE_X8:   scaled = ext <<< 3;
            RATE_X4:   scaled = ext <<< 2;
            RATE_X2:   scaled = ext <<< 1;
            RATE_X1:   scaled = ext;
            RATE_HALF: scaled = ext >>> 1;
            default:   scaled = ext;
        endcase
    end

endmodule

// File: rtl/slew_saturate.sv
module slew_saturate #(
    parameter int unsigned IN_W  = 23,
    parameter int unsigned OUT_W = 14
) (
    input  logic signed [IN_W-1:0]  wide,
    output logic signed [OUT_W-1:0] clamped
);

    localparam int unsigned HI_W = IN_W - OUT_W + 1;

    logic [HI_W-1:0] hi_bits;

    always_comb begin
        hi_bits = wide[IN_W-1:OUT_W-1];
        if ((&hi_bits) || !(|hi_bits)) begin
            clamped = wide[OUT_W-1:0];
        end else if (wide[IN_W-1]) begin
            clamped = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            clamped = {1'b0, {(OUT_W-1){1'b1}}};
        end
    end

endmodule

// File: rtl/slew_limit_cmp.sv
module slew_limit_cmp #(
    parameter int unsigned RES_W = 14,
    parameter int unsigned LIM_W = 13
) (
    input  logic signed [RES_W-1:0] result,
    input  logic [LIM_W-1:0]        limit,
    output logic                    exceeds
);

    localparam int unsigned CMP_W = (RES_W - 1 > LIM_W) ? RES_W - 1 : LIM_W;

    logic [CMP_W-1:0] mag;
    logic [CMP_W-1:0] lim_ext;

    always_comb begin
        mag     = CMP_W'(result[RES_W-2:0]);
        lim_ext = CMP_W'(limit);
        exceeds = !result[RES_W-1] && (mag > lim_ext);
    end

endmodule

// File: rtl/slew_rate_monitor.sv
module slew_rate_monitor
    import slew_mon_pkg::*;
#(
    parameter int unsigned TEMP_W = 14,
    parameter int unsigned LIM_W  = 13,
    parameter int unsigned PAD_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_valid,
    input  logic signed [TEMP_W-1:0] sample_temp,
    input  logic                     cont_mode,
    input  logic [2:0]               rate_code,
    input  logic [LIM_W-1:0]         slew_limit,
    output logic [TEMP_W+PAD_W-1:0]  slew_word,
    output logic                     slew_high,
    output logic                     slew_event
);

    localparam int unsigned WIDE_W = TEMP_W + 1 + SCALE_HEADROOM;

    typedef struct packed {
        logic signed [TEMP_W-1:0] prev;
        logic                     have_prev;
        logic signed [TEMP_W-1:0] slew;
        logic                     high;
        logic                     evt;
    } mon_state_t;

    mon_state_t st_d, st_q;

    logic signed [WIDE_W-1:0] scaled_w;
    logic signed [TEMP_W-1:0] clamped_w;
    logic                     over_w;

    slew_diff_scale #(
        .IN_W   (TEMP_W),
        .WIDE_W (WIDE_W)
    ) u_scale (
        .cur_sample  (sample_temp),
        .prev_sample (st_q.prev),
        .rate_code   (rate_code),
        .scaled      (scaled_w)
    );

    slew_saturate #(
        .IN_W  (WIDE_W),
        .OUT_W (TEMP_W)
    ) u_sat (
        .wide    (scaled_w),
        .clamped (clamped_w)
    );

    slew_limit_cmp #(
        .RES_W (TEMP_W),
        .LIM_W (LIM_W)
    ) u_cmp (
        .result  (clamped_w),
        .limit   (slew_limit),
        .exceeds (over_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        if (!cont_mode) begin
            st_d.prev      = '0;
            st_d.have_prev = 1'b0;
            st_d.slew      = '0;
            st_d.high      = 1'b0;
        end else if (sample_valid) begin
            st_d.prev      = sample_temp;
            st_d.have_prev = 1'b1;
            if (st_q.have_prev) begin
                st_d.slew = clamped_w;
                st_d.high = over_w;
                st_d.evt  = over_w && !st_q.high;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slew_word  = {st_q.slew, {PAD_W{1'b0}}};
    assign slew_high  = st_q.high;
    assign slew_event = st_q.evt;

endmodule

// File: rtl/slew_rate_monitor_chk.sv
module slew_rate_monitor_chk #(
    parameter int unsigned WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_valid,
    input logic              cont_mode,
    input logic [WORD_W-1:0] slew_word,
    input logic              slew_high,
    input logic              slew_event
);

    // R6
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slew_word[1:0] == 2'b00);

    // R5
    leave_cont_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cont_mode |=> (slew_word == '0) && !slew_high && !slew_event);

    // R7
    high_means_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slew_high |-> !slew_word[WORD_W-1]);

    // R8
    event_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slew_event |-> slew_high);

    // R8
    event_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slew_event |=> !slew_event);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_mode && !sample_valid) |=> $stable(slew_word) && $stable(slew_high) && !slew_event);

endmodule

bind slew_rate_monitor slew_rate_monitor_chk #(
    .WORD_W (TEMP_W + PAD_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .cont_mode    (cont_mode),
    .slew_word    (slew_word),
    .slew_high    (slew_high),
    .slew_event   (slew_event)
);

// File: tb/slew_rate_monitor_bench.sv
module slew_rate_monitor_bench;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sample_valid = 1'b0;
    logic signed [13:0] sample_temp = '0;
    logic               cont_mode = 1'b1;
    logic [2:0]         rate_code = 3'd6;
    logic [12:0]        slew_limit = 13'h0140;
    logic [15:0]        slew_word;
    logic               slew_high;
    logic               slew_event;

    int compared = 0;
    int mismatched = 0;

    // bench model of the requirements
    int m_prev = 0;
    bit m_have = 0;
    int m_slew = 0;
    bit m_high = 0;

    always #2 clk = ~clk;

    slew_rate_monitor u_slew_rate_monitor (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample_temp  (sample_temp),
        .cont_mode    (cont_mode),
        .rate_code    (rate_code),
        .slew_limit   (slew_limit),
        .slew_word    (slew_word),
        .slew_high    (slew_high),
        .slew_event   (slew_event)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int expect_slew(input int diff, input int code);
        int v;
        case (code)
            0: v = diff * 166;
            7: v = (diff >= 0) ? diff / 2 : -((-diff + 1) / 2);
            default: v = diff * (1 << (6 - code));
        endcase
        if (v > 8191) v = 8191;
        if (v < -8192) v = -8192;
        return v;
    endfunction

    function automatic int word_value(input logic [15:0] w);
        logic signed [13:0] r;
        r = w[15:2];
        return int'(r);
    endfunction

    task automatic check_outputs(input string req, input bit exp_evt);
        check(req, "slew value", word_value(slew_word), m_slew);
        check("R6", "low bits", int'(slew_word[1:0]), 0);
        check(req, "slew_high", int'(slew_high), int'(m_high));
        check(req, "slew_event", int'(slew_event), int'(exp_evt));
    endtask

    task automatic send(input int t, input string req);
        bit evt;
        evt = 0;
        @(negedge clk);
        sample_temp  = 14'(t);
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        if (m_have) begin
            bit nh;
            m_slew = expect_slew(t - m_prev, int'(rate_code));
            nh = (m_slew >= 0) && (m_slew > int'(slew_limit));
            evt = nh && !m_high;
            m_high = nh;
        end
        m_prev = t;
        m_have = 1;
        check_outputs(req, evt);
    endtask

    task automatic t_reset();
        check("R1", "reset word", int'(slew_word), 0);
        check("R1", "reset high", int'(slew_high), 0);
        check("R1", "reset event", int'(slew_event), 0);
    endtask

    task automatic t_two_sample();
        rate_code = 3'd6;
        send(100, "R2");          // first sample: no result
        send(150, "R2");          // second: 50
    endtask

    task automatic t_rates();
        rate_code = 3'd0; send(153, "R3");   // 3*166 = 498, crosses 320
        rate_code = 3'd1; send(150, "R3");   // -3*32
        rate_code = 3'd2; send(160, "R3");
        rate_code = 3'd3; send(170, "R3");
        rate_code = 3'd4; send(190, "R3");
        rate_code = 3'd5; send(200, "R3");
        rate_code = 3'd6; send(210, "R3");
        rate_code = 3'd7; send(207, "R3");   // -3 halved -> -2
        send(213, "R3");                     // +6 halved -> 3
    endtask

    task automatic t_saturate();
        rate_code = 3'd1;
        send(7000, "R4");         // clamps to 8191
        send(-7000, "R4");        // clamps to -8192
    endtask

    task automatic t_limit();
        rate_code  = 3'd6;
        slew_limit = 13'd100;
        send(0, "R7");            // +7000, exceeds, event
        send(100, "R7");          // equal to limit: low
        send(201, "R8");          // 101: high, event
        send(302, "R8");          // 101 again: high, no event
        send(250, "R7");          // negative: low
        slew_limit = 13'd0;
        send(250, "R7");          // zero equals zero: low
        send(251, "R8");          // 1 > 0: event
    endtask

    task automatic t_exit();
        @(negedge clk);
        cont_mode    = 1'b0;
        sample_valid = 1'b1;      // must be ignored
        sample_temp  = 14'sd900;
        @(negedge clk);
        sample_valid = 1'b0;
        m_have = 0; m_slew = 0; m_high = 0;
        check_outputs("R5", 1'b0);
        cont_mode = 1'b1;
        send(500, "R5");          // first after re-entry: still zero
        send(505, "R2");          // now 5 > 0
    endtask

    task automatic t_hold();
        rate_code  = 3'd1;
        slew_limit = 13'd4000;
        repeat (5) @(negedge clk);
        check_outputs("R9", 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_two_sample();
        t_rates();
        t_saturate();
        t_limit();
        t_exit();
        t_hold();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule